// File: doc/BRIEF.md
# Packed Colour Lookup Table

This block is a 256-entry colour lookup table for a display pipeline. The entries are held two to a 32-bit word, so the storage is 128 words deep. A register-side port writes and reads whole words. Each word carries a pair of 16-bit colour entries. Each entry holds three 5-bit colour channels and one intensity bit, which the block ignores.

A pixel-side port takes an 8-bit palette index. One clock later it returns a 24-bit colour. The index picks a word and then one half of it. The three channels are widened to 8 bits each by appending three zero bits. A per-request swap control can exchange the first and third channels to give blue-green-red order. Address decoding on the register side is done by the surrounding logic. So is the unpacking of frame-buffer pixels into indices.

Top module: `colour_lut`

## Requirements
- R1: While reset is asserted and after it is released, `pix_rgb` is 0, `pix_rgb_valid` is 0 and `reg_rdata` is 0, until the first request on the matching port.
- R2: A register write with `reg_wr_en` high stores all 32 bits of `reg_wdata` at word `reg_addr`. A read with `reg_rd_en` high returns that word on `reg_rdata` after the next clock edge. `reg_rdata` holds its value while `reg_rd_en` is low.
- R3: Lookup index bits [7:1] select the word. Index bit 0 selects the half: 0 selects word bits [15:0] and 1 selects word bits [31:16].
- R4: Within an entry, channel A is bits [4:0], channel B is bits [9:5] and channel C is bits [14:10]. Each channel is output as its 5 bits followed by three zero bits, so 5'h1F gives 8'hF8. Bit 15 of the entry has no effect on the output.
- R5: With `pix_bgr` at 0, `pix_rgb[7:0]` is channel A, `[15:8]` is channel B and `[23:16]` is channel C. With `pix_bgr` at 1, channels A and C trade places and B stays in the middle. `pix_bgr` is sampled with the index.
- R6: `pix_rgb` and `pix_rgb_valid` respond one clock edge after the edge that samples `pix_valid`. `pix_rgb_valid` is high for exactly the cycles that follow a request. `pix_rgb` holds its value when there is no request.
- R7: If a word is written on the same edge that either port reads it, that port returns the word's old contents. The new contents are returned from the next read onward.
- R8: One word write replaces both entries packed in that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register-side word write strobe |
| reg_rd_en | input | 1 | Register-side word read strobe |
| reg_addr | input | 7 | Word address for the register-side read and write |
| reg_wdata | input | 32 | Word to write |
| reg_rdata | output | 32 | Word read, registered |
| pix_valid | input | 1 | Lookup request |
| pix_index | input | 8 | Palette index for the lookup |
| pix_bgr | input | 1 | Swap the first and third channels on output |
| pix_rgb | output | 24 | Expanded colour, registered path |
| pix_rgb_valid | output | 1 | High in the cycle after a lookup request |

## Verification
A wrong half-select or a wrong word address shows up as a wrong 24-bit colour one cycle after the faulty request. Such an error never persists silently past that cycle. A fault in channel widening or in the swap shows up as nonzero low bits or as exchanged bytes in that same cycle. Corrupted storage or a lost write stays hidden until the word is read. So the bench writes the whole table and then reads words back through both ports, including on the edge of a write, where stale or new data shows up within one clock.

// File: rtl/clut_pkg.sv
package clut_pkg;

  // Width of one stored colour channel.
  localparam int CH_W     = 5;
  // Channels per entry.
  localparam int NUM_CH   = 3;
  // Width of one packed entry: three channels plus an intensity bit.
  localparam int ENTRY_W  = 16;
  // Entries packed into each storage word.
  localparam int HALVES   = 2;
  localparam int WORD_W   = ENTRY_W * HALVES;
  // Number of storage read ports (register side, pixel side).
  localparam int RD_PORTS = 2;
  localparam int PORT_REG = 0;
  localparam int PORT_PIX = 1;

  typedef logic [ENTRY_W-1:0] entry_t;
  typedef logic [WORD_W-1:0]  word_t;

  function automatic entry_t pick_half(input word_t w, input logic upper);
    return upper ? w[WORD_W-1:ENTRY_W] : w[ENTRY_W-1:0];
  endfunction

endpackage

// File: rtl/clut_word_store.sv
module clut_word_store
  import clut_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = WORD_W
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [ADDR_W-1:0]                 wr_addr,
  input  logic [DATA_W-1:0]                 wr_data,
  input  logic [RD_PORTS-1:0]               rd_en,
  input  logic [RD_PORTS-1:0][ADDR_W-1:0]   rd_addr,
  output logic [RD_PORTS-1:0][DATA_W-1:0]   rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  // Storage array: no reset, written on its own enable.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  // One registered read port per requester; reads see pre-write contents.
  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] data_nxt;

    always_comb begin
      data_nxt = data_q;
      if (rd_en[p]) begin
        data_nxt = mem_q[rd_addr[p]];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q <= '0;
      end else begin
        data_q <= data_nxt;
      end
    end

    assign rd_data[p] = data_q;
  end

endmodule

// File: rtl/clut_expand.sv
module clut_expand
  import clut_pkg::*;
#(
  parameter int OUT_CH_W = 8
) (
  input  logic [ENTRY_W-1:0]         entry,
  input  logic                       swap,
  output logic [NUM_CH*OUT_CH_W-1:0] rgb
);

  localparam int PAD = OUT_CH_W - CH_W;

  logic [NUM_CH-1:0][OUT_CH_W-1:0] wide;
  logic                            unused_intensity;

  assign unused_intensity = entry[ENTRY_W-1];

  // Widen each channel by appending zero bits.
  for (genvar c = 0; c < NUM_CH; c++) begin : g_widen
    assign wide[c] = {entry[c*CH_W +: CH_W], {PAD{1'b0}}};
  end

  // Place channels; the swap mirrors the slot order, the centre stays.
  for (genvar s = 0; s < NUM_CH; s++) begin : g_place
    assign rgb[s*OUT_CH_W +: OUT_CH_W] = swap ? wide[NUM_CH-1-s] : wide[s];
  end

endmodule

// File: rtl/colour_lut.sv
module colour_lut
  import clut_pkg::*;
#(
  parameter int IDX_W    = 8,
  parameter int OUT_CH_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_wr_en,
  input  logic                       reg_rd_en,
  input  logic [IDX_W-2:0]           reg_addr,
  input  logic [WORD_W-1:0]          reg_wdata,
  output logic [WORD_W-1:0]          reg_rdata,
  input  logic                       pix_valid,
  input  logic [IDX_W-1:0]           pix_index,
  input  logic                       pix_bgr,
  output logic [NUM_CH*OUT_CH_W-1:0] pix_rgb,
  output logic                       pix_rgb_valid
);

  localparam int WADDR_W = IDX_W - 1;

  logic [RD_PORTS-1:0]               rd_en;
  logic [RD_PORTS-1:0][WADDR_W-1:0]  rd_addr;
  logic [RD_PORTS-1:0][WORD_W-1:0]   rd_data;

  logic   half_q,  half_nxt;
  logic   swap_q,  swap_nxt;
  logic   vld_q,   vld_nxt;
  entry_t sel_entry;

  assign rd_en[PORT_REG]   = reg_rd_en;
  assign rd_addr[PORT_REG] = reg_addr;
  assign rd_en[PORT_PIX]   = pix_valid;
  assign rd_addr[PORT_PIX] = pix_index[IDX_W-1:1];

  clut_word_store #(
    .ADDR_W (WADDR_W),
    .DATA_W (WORD_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr_en),
    .wr_addr (reg_addr),
    .wr_data (reg_wdata),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  // Lookup side-band: half select and swap travel with the word read.
  always_comb begin
    half_nxt = half_q;
    swap_nxt = swap_q;
    vld_nxt  = pix_valid;
    if (pix_valid) begin
      half_nxt = pix_index[0];
      swap_nxt = pix_bgr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      swap_q <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      half_q <= half_nxt;
      swap_q <= swap_nxt;
      vld_q  <= vld_nxt;
    end
  end

  assign sel_entry = pick_half(rd_data[PORT_PIX], half_q);

  clut_expand #(
    .OUT_CH_W (OUT_CH_W)
  ) u_expand (
    .entry (sel_entry),
    .swap  (swap_q),
    .rgb   (pix_rgb)
  );

  assign reg_rdata     = rd_data[PORT_REG];
  assign pix_rgb_valid = vld_q;

endmodule

// File: rtl/colour_lut_chk.sv
module colour_lut_chk
  import clut_pkg::*;
#(
  parameter int OUT_CH_W = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       pix_valid,
  input logic                       reg_rd_en,
  input logic [WORD_W-1:0]          reg_rdata,
  input logic [NUM_CH*OUT_CH_W-1:0] pix_rgb,
  input logic                       pix_rgb_valid
);

  localparam int RGB_W = NUM_CH * OUT_CH_W;
  localparam int PAD   = OUT_CH_W - CH_W;

  function automatic logic [RGB_W-1:0] low_mask();
    logic [RGB_W-1:0] m;
    m = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      for (int b = 0; b < PAD; b++) begin
        m[c*OUT_CH_W + b] = 1'b1;
      end
    end
    return m;
  endfunction

  localparam logic [RGB_W-1:0] LOW_MASK = low_mask();

  // R1: outputs come out of reset cleared
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pix_rgb == '0 && !pix_rgb_valid && reg_rdata == '0));

  // R2: register read data holds without a read
  p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd_en |=> $stable(reg_rdata));

  // R4: widened channels carry zero low bits
  p_low_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pix_rgb_valid |-> ((pix_rgb & LOW_MASK) == '0));

  // R6: valid follows a request by one edge
  p_valid_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> pix_rgb_valid);

  // R6: no request, no valid
  p_valid_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> !pix_rgb_valid);

  // R6: colour holds without a request
  p_rgb_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> $stable(pix_rgb));

endmodule

bind colour_lut colour_lut_chk #(.OUT_CH_W(OUT_CH_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .pix_valid     (pix_valid),
  .reg_rd_en     (reg_rd_en),
  .reg_rdata     (reg_rdata),
  .pix_rgb       (pix_rgb),
  .pix_rgb_valid (pix_rgb_valid)
);

// File: tb/tb_colour_lut.sv
module tb_colour_lut;

  logic        clk;
  logic        rst_n;
  logic        reg_wr_en;
  logic        reg_rd_en;
  logic [6:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        pix_valid;
  logic [7:0]  pix_index;
  logic        pix_bgr;
  logic [23:0] pix_rgb;
  logic        pix_rgb_valid;

  int n_checks;
  int n_fail;
  bit finished;
  logic [31:0] model [128];

  colour_lut dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_wr_en     (reg_wr_en),
    .reg_rd_en     (reg_rd_en),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .pix_valid     (pix_valid),
    .pix_index     (pix_index),
    .pix_bgr       (pix_bgr),
    .pix_rgb       (pix_rgb),
    .pix_rgb_valid (pix_rgb_valid)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic logic [23:0] exp_rgb(input logic [31:0] w, input logic upper,
                                          input logic bgr);
    logic [15:0] e;
    logic [7:0]  a, b, c;
    e = upper ? w[31:16] : w[15:0];
    a = {e[4:0], 3'b000};
    b = {e[9:5], 3'b000};
    c = {e[14:10], 3'b000};
    return bgr ? {a, b, c} : {c, b, a};
  endfunction

  function automatic logic [31:0] pattern(input int i);
    return 32'hA5C3_1E27 ^ (i * 32'h0101_0DB3);
  endfunction

  task automatic write_word(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1;
    reg_addr  = a;
    reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
    model[a]  = d;
  endtask

  task automatic read_word(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd_en = 1'b1;
    reg_addr  = a;
    @(negedge clk);
    reg_rd_en = 1'b0;
    d = reg_rdata;
  endtask

  task automatic lookup(input logic [7:0] idx, input logic bgr,
                        output logic [23:0] rgb, output logic vld);
    @(negedge clk);
    pix_valid = 1'b1;
    pix_index = idx;
    pix_bgr   = bgr;
    @(negedge clk);
    pix_valid = 1'b0;
    rgb = pix_rgb;
    vld = pix_rgb_valid;
  endtask

  task automatic t_reset();
    rst_n     = 1'b0;
    reg_wr_en = 1'b0;
    reg_rd_en = 1'b0;
    reg_addr  = '0;
    reg_wdata = '0;
    pix_valid = 1'b0;
    pix_index = '0;
    pix_bgr   = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "rgb in reset", {8'h0, pix_rgb}, 32'h0);
    check("R1", "valid in reset", {31'h0, pix_rgb_valid}, 32'h0);
    check("R1", "rdata in reset", reg_rdata, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1", "rgb after release", {8'h0, pix_rgb}, 32'h0);
    check("R1", "rdata after release", reg_rdata, 32'h0);
  endtask

  task automatic t_fill_and_read();
    logic [31:0] d;
    for (int i = 0; i < 128; i++) write_word(7'(i), pattern(i));
    foreach (model[i]) begin
      if (i % 9 == 0 || i == 127) begin
        read_word(7'(i), d);
        check("R2", "word readback", d, model[i]);
      end
    end
    // R2: hold while no read
    @(negedge clk);
    reg_addr = 7'd3;
    @(negedge clk);
    check("R2", "rdata hold", reg_rdata, model[127]);
  endtask

  task automatic t_index_map();
    logic [23:0] rgb;
    logic        v;
    for (int k = 0; k < 10; k++) begin
      logic [7:0] idx;
      idx = (k < 4) ? ((k < 2) ? 8'(k) : 8'(252 + k)) : 8'(k * 37 + 5);
      lookup(idx, 1'b0, rgb, v);
      check("R3", "lookup by index", {8'h0, rgb}, {8'h0, exp_rgb(model[idx[7:1]], idx[0], 1'b0)});
      check("R6", "valid after request", {31'h0, v}, 32'h1);
    end
  endtask

  task automatic t_fields_and_swap();
    logic [23:0] rgb, rgb2;
    logic        v;
    // Distinct channels: A=1F, B=01, C=10 in lower half; upper half bit15 set.
    write_word(7'd20, {1'b1, 5'h10, 5'h01, 5'h1F, 1'b0, 5'h10, 5'h01, 5'h1F});
    lookup(8'd40, 1'b0, rgb, v);
    check("R4", "channel widen", {8'h0, rgb}, {8'h0, 8'h80, 8'h08, 8'hF8});
    lookup(8'd41, 1'b0, rgb2, v);
    check("R4", "intensity bit ignored", {8'h0, rgb2}, {8'h0, rgb});
    lookup(8'd40, 1'b1, rgb, v);
    check("R5", "bgr swap", {8'h0, rgb}, {8'h0, 8'hF8, 8'h08, 8'h80});
    lookup(8'd77, 1'b1, rgb, v);
    check("R5", "bgr swap pattern", {8'h0, rgb}, {8'h0, exp_rgb(model[38], 1'b1, 1'b1)});
  endtask

  task automatic t_latency_hold();
    logic [23:0] rgb;
    logic        v;
    lookup(8'd9, 1'b0, rgb, v);
    check("R6", "request result", {8'h0, rgb}, {8'h0, exp_rgb(model[4], 1'b1, 1'b0)});
    pix_index = 8'd200;
    pix_bgr   = 1'b1;
    @(negedge clk);
    check("R6", "valid drops", {31'h0, pix_rgb_valid}, 32'h0);
    check("R6", "rgb holds", {8'h0, pix_rgb}, {8'h0, rgb});
  endtask

  task automatic t_same_cycle();
    logic [23:0] rgb;
    logic        v;
    logic [31:0] old_w;
    logic [31:0] d;
    old_w = model[50];
    @(negedge clk);
    reg_wr_en = 1'b1;
    reg_rd_en = 1'b1;
    reg_addr  = 7'd50;
    reg_wdata = 32'h7C1F_03E0;
    pix_valid = 1'b1;
    pix_index = 8'd101;
    pix_bgr   = 1'b0;
    @(negedge clk);
    reg_wr_en = 1'b0;
    reg_rd_en = 1'b0;
    pix_valid = 1'b0;
    model[50] = 32'h7C1F_03E0;
    check("R7", "reg port old data", reg_rdata, old_w);
    check("R7", "pix port old data", {8'h0, pix_rgb}, {8'h0, exp_rgb(old_w, 1'b1, 1'b0)});
    read_word(7'd50, d);
    check("R7", "reg port new data", d, 32'h7C1F_03E0);
    lookup(8'd101, 1'b0, rgb, v);
    check("R7", "pix port new data", {8'h0, rgb}, {8'h0, exp_rgb(32'h7C1F_03E0, 1'b1, 1'b0)});
  endtask

  task automatic t_both_halves();
    logic [23:0] rgb;
    logic        v;
    write_word(7'd100, 32'h2108_56B5);
    lookup(8'd200, 1'b0, rgb, v);
    check("R8", "lower entry updated", {8'h0, rgb}, {8'h0, exp_rgb(32'h2108_56B5, 1'b0, 1'b0)});
    lookup(8'd201, 1'b0, rgb, v);
    check("R8", "upper entry updated", {8'h0, rgb}, {8'h0, exp_rgb(32'h2108_56B5, 1'b1, 1'b0)});
  endtask

  initial begin
    n_checks = 0;
    n_fail   = 0;
    finished = 1'b0;
    t_reset();
    t_fill_and_read();
    t_index_map();
    t_fields_and_swap();
    t_latency_hold();
    t_same_cycle();
    t_both_halves();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule